// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. The comparator, the capacitive trial DAC and the sample/hold switches are analog parts outside the block. Here they appear only as a one-bit comparator input and as control outputs. While idle, the sequencer keeps the sample switches closed and the comparator zeroed. It refuses a start until a minimum acquire time has passed.

A start is requested by holding chip select and convert-start low together. The sequencer then clears its approximation register and releases comparator zeroing. One cycle later it switches the sample/hold to hold. It then resolves one bit per clock, from the most significant bit downward, by presenting trial codes to the DAC. The final word is copied into a separate output latch, with a one-cycle valid strobe. The block then returns to the acquire phase. A request that arrives while a conversion is running has no effect.

Top module: `sar_seq`

## Requirements
- R1: A conversion starts only at a rising clock edge where `cs_n` and `conv_n` are both low, in the acquire phase, with the acquire time met. `cs_n` high or `conv_n` high on its own never starts one.
- R2: On the accepted start the approximation register is cleared, so `dac_code` is 0 in both set-up cycles that follow.
- R3: A start request made while `busy` is high is ignored. It is not remembered, and it causes no conversion after the current one ends.
- R4: The acquire phase lasts at least ACQ_CYCLES = ceil(ACQ_MIN_NS / CLK_PERIOD_NS) cycles, counted from the cycle after the result latch update. A request held continuously is accepted at exactly that point.
- R5: In the first busy cycle `zero_en` is low and `sample_en` is still high. In the second busy cycle both are low. Bit trials start in the third cycle.
- R6: The sequencer makes WIDTH trials, one per cycle, for bit WIDTH-1 down to bit 0. During the trial for bit b, `dac_code` equals the bits already resolved above b, with bit b set to 1 and the lower bits at 0. `comp_hi` = 1 keeps bit b and 0 clears it.
- R7: `result` keeps its previous value throughout a conversion. It takes the resolved word at the clock edge that ends the last trial.
- R8: `busy` is high from the edge that accepts a start until the edge that updates `result`, and it falls on that same edge.
- R9: `result_valid` is high for exactly one cycle, the first cycle in which the new `result` is visible.
- R10: After the latch update, `zero_en` and `sample_en` are high again and the acquire count restarts from zero.
- R11: A request seen in the acquire phase before the time is met is held pending. It starts a conversion as soon as the time is met, even if the request was released in the meantime.
- R12: After reset, `busy` = 0, `result_valid` = 0, `result` = 0, `sample_en` = 1 and `zero_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| conv_n | input | 1 | Convert-start request, active low |
| comp_hi | input | 1 | Comparator decision, 1 = input above the trial level |
| dac_code | output | WIDTH | Trial code driven to the DAC |
| sample_en | output | 1 | 1 = sample switches closed (track), 0 = hold |
| zero_en | output | 1 | 1 = comparator offset zeroing active |
| busy | output | 1 | Conversion in progress |
| result | output | WIDTH | Latched conversion result |
| result_valid | output | 1 | One-cycle strobe on a result update |

## Verification
Several internal faults show up at the ports within one conversion. A wrong bit index or trial mask shows up in `dac_code` during the trial it affects, and in `result` about WIDTH+2 cycles after the start. A wrong acquire count or pending flag moves the rising edge of `busy` away from exactly ACQ_CYCLES cycles after the previous strobe. A sequencing fault shifts the `zero_en` and `sample_en` transitions by a cycle within the first three busy cycles. The bench sweeps every input code of a narrow configuration back-to-back, so every trial path and the acquire timing are exercised on each conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_ACQUIRE = 2'd0,
        PH_UNZERO  = 2'd1,
        PH_HOLD    = 2'd2,
        PH_TRIAL   = 2'd3
    } phase_e;

endpackage

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int CYCLES = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic met
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_limit;

    assign at_limit = (cnt_q == CW'(CYCLES - 1));
    assign met      = run && at_limit;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (!at_limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sar_bit_trial.sv
module sar_bit_trial #(
    parameter int WIDTH = 14,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] code,
    input  logic [IW-1:0]    idx,
    input  logic             comp,
    output logic [WIDTH-1:0] resolved,
    output logic [WIDTH-1:0] next_code
);
    always_comb begin
        resolved      = code;
        resolved[idx] = comp;
        next_code     = resolved;
        if (idx != '0) begin
            next_code[idx - 1'b1] = 1'b1;
        end
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int WIDTH         = 14,
    parameter int CLK_PERIOD_NS = 5,
    parameter int ACQ_MIN_NS    = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             conv_n,
    input  logic             comp_hi,
    output logic [WIDTH-1:0] dac_code,
    output logic             sample_en,
    output logic             zero_en,
    output logic             busy,
    output logic [WIDTH-1:0] result,
    output logic             result_valid
);
    import sar_seq_pkg::*;

    localparam int IW          = $clog2(WIDTH);
    localparam int ACQ_RAW     = (ACQ_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int ACQ_CYCLES  = (ACQ_RAW < 1) ? 1 : ACQ_RAW;

    typedef struct packed {
        phase_e           phase;
        logic [WIDTH-1:0] code;
        logic [IW-1:0]    idx;
        logic             pend;
        logic             busy;
        logic [WIDTH-1:0] result;
        logic             valid;
    } seq_t;

    seq_t s_d, s_q;

    logic             req;
    logic             acq_met;
    logic [WIDTH-1:0] trial_resolved;
    logic [WIDTH-1:0] trial_next;

    assign req = !cs_n && !conv_n;

    sar_acq_timer #(
        .CYCLES (ACQ_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.phase == PH_ACQUIRE),
        .met   (acq_met)
    );

    sar_bit_trial #(
        .WIDTH (WIDTH)
    ) u_trial (
        .code      (s_q.code),
        .idx       (s_q.idx),
        .comp      (comp_hi),
        .resolved  (trial_resolved),
        .next_code (trial_next)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        unique case (s_q.phase)
            PH_ACQUIRE: begin
                if (acq_met && (req || s_q.pend)) begin
                    s_d.phase = PH_UNZERO;
                    s_d.code  = '0;
                    s_d.pend  = 1'b0;
                    s_d.busy  = 1'b1;
                end else if (req) begin
                    s_d.pend = 1'b1;
                end
            end
            PH_UNZERO: begin
                s_d.phase = PH_HOLD;
            end
            PH_HOLD: begin
                s_d.phase = PH_TRIAL;
                s_d.code  = {1'b1, {(WIDTH-1){1'b0}}};
                s_d.idx   = IW'(WIDTH - 1);
            end
            PH_TRIAL: begin
                if (s_q.idx == '0) begin
                    s_d.code   = trial_resolved;
                    s_d.result = trial_resolved;
                    s_d.valid  = 1'b1;
                    s_d.busy   = 1'b0;
                    s_d.phase  = PH_ACQUIRE;
                end else begin
                    s_d.code = trial_next;
                    s_d.idx  = s_q.idx - 1'b1;
                end
            end
            default: s_d.phase = PH_ACQUIRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_ACQUIRE, code: '0, idx: '0, pend: 1'b0,
                     busy: 1'b0, result: '0, valid: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_code     = s_q.code;
    assign sample_en    = (s_q.phase == PH_ACQUIRE) || (s_q.phase == PH_UNZERO);
    assign zero_en      = (s_q.phase == PH_ACQUIRE);
    assign busy         = s_q.busy;
    assign result       = s_q.result;
    assign result_valid = s_q.valid;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int WIDTH         = 14,
    parameter int CLK_PERIOD_NS = 5,
    parameter int ACQ_MIN_NS    = 400
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] dac_code,
    input logic             sample_en,
    input logic             zero_en,
    input logic             busy,
    input logic [WIDTH-1:0] result,
    input logic             result_valid
);
    localparam int ACQ_RAW    = (ACQ_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int ACQ_CYCLES = (ACQ_RAW < 1) ? 1 : ACQ_RAW;
    localparam int CW         = $clog2(ACQ_CYCLES + 1);

    logic [CW-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (busy) begin
            idle_q <= '0;
        end else if (idle_q != CW'(ACQ_CYCLES)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R4
    acq_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (idle_q >= CW'(ACQ_CYCLES)));

    // R2
    sar_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_code == '0));

    // R5
    zero_before_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_en) |-> (!zero_en && $past(!zero_en)));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> result_valid);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));

    // R10
    reacquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (zero_en && sample_en && !busy));
endmodule

bind sar_seq sar_seq_chk #(
    .WIDTH         (WIDTH),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .ACQ_MIN_NS    (ACQ_MIN_NS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dac_code     (dac_code),
    .sample_en    (sample_en),
    .zero_en      (zero_en),
    .busy         (busy),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/tb_sar_seq.sv
`timescale 1ns/1ps
module tb_sar_seq;
    localparam int W   = 8;
    localparam int P   = 5;
    localparam int AN  = 40;
    localparam int ACQ = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         conv_n = 1'b1;
    logic         comp_hi;
    logic [W-1:0] vin = '0;
    logic [W-1:0] dac_code;
    logic         sample_en, zero_en, busy, result_valid;
    logic [W-1:0] result;

    int  tests = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    // analog model: input at or above trial level reads as high
    assign comp_hi = (vin >= dac_code);

    sar_seq #(.WIDTH(W), .CLK_PERIOD_NS(P), .ACQ_MIN_NS(AN)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .conv_n(conv_n), .comp_hi(comp_hi),
        .dac_code(dac_code), .sample_en(sample_en), .zero_en(zero_en), .busy(busy),
        .result(result), .result_valid(result_valid)
    );

    initial forever #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // idle window: busy must stay low
    task automatic expect_idle(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        chk(!seen, req, "busy during idle window", int'(seen), 0);
    endtask

    // one conversion; called at a negedge; returns at the negedge after the strobe cycle
    task automatic convert(input logic [W-1:0] v, input logic [W-1:0] prev,
                           input int exp_wait, input bit pulse, input bit retrig);
        logic [W-1:0] exp_code;
        int waited = 0;
        vin = v; cs_n = 1'b0; conv_n = 1'b0;
        @(negedge clk);
        if (pulse) begin cs_n = 1'b1; conv_n = 1'b1; end
        while (!busy && waited < 1000) begin
            waited++;
            @(negedge clk);
            cs_n = 1'b1; if (!pulse) cs_n = 1'b0;
            if (pulse) conv_n = 1'b1;
        end
        cs_n = 1'b1; conv_n = 1'b1;
        if (exp_wait >= 0)
            chk(waited == exp_wait, pulse ? "R11" : "R4", "cycles to start", waited, exp_wait);
        chk(!zero_en && sample_en, "R5", "first busy cycle zero/sample",
            int'({zero_en, sample_en}), 1);
        chk(dac_code == '0, "R2", "code after start", int'(dac_code), 0);
        chk(result == prev, "R7", "latch during set-up", int'(result), int'(prev));
        @(negedge clk);
        chk(!zero_en && !sample_en && busy, "R5", "hold cycle",
            int'({busy, zero_en, sample_en}), 4);
        chk(dac_code == '0, "R2", "code in hold cycle", int'(dac_code), 0);
        exp_code = '0;
        for (int b = W - 1; b >= 0; b--) begin
            if (retrig && b == W / 2) begin cs_n = 1'b0; conv_n = 1'b0; end
            @(negedge clk);
            if (retrig) begin cs_n = 1'b1; conv_n = 1'b1; end
            chk(dac_code == (exp_code | (W'(1) << b)), "R6", "trial code",
                int'(dac_code), int'(exp_code | (W'(1) << b)));
            chk(busy && result == prev, "R7", "busy and latch held in trial",
                int'(result), int'(prev));
            if (v[b]) exp_code = exp_code | (W'(1) << b);
        end
        @(negedge clk);
        chk(result_valid && result == v, "R6", "latched result", int'(result), int'(v));
        chk(!busy, "R8", "busy falls with latch", int'(busy), 0);
        chk(zero_en && sample_en, "R10", "reacquire", int'({zero_en, sample_en}), 3);
        @(negedge clk);
        chk(!result_valid, "R9", "strobe width", int'(result_valid), 0);
    endtask

    initial begin
        #(200000 * P);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [W-1:0] prev;
        repeat (3) @(negedge clk);
        chk(!busy && !result_valid && result == '0 && sample_en && zero_en, "R12",
            "reset outputs", int'({busy, result_valid, sample_en, zero_en}), 3);
        rst_n = 1'b1;
        // R1: only one of the two strobes low never starts
        cs_n = 1'b1; conv_n = 1'b0;
        expect_idle(3 * ACQ, "R1");
        cs_n = 1'b0; conv_n = 1'b1;
        expect_idle(3 * ACQ, "R1");
        cs_n = 1'b1;
        convert(8'hA5, '0, 0, 1'b0, 1'b0);
        prev = 8'hA5;
        // R4: back-to-back sweep over every code
        for (int v = 0; v < (1 << W); v++) begin
            convert(W'(v), prev, ACQ - 2, 1'b0, 1'b0);
            prev = W'(v);
        end
        // R11: one-cycle early request is held pending
        convert(8'h3C, prev, ACQ - 2, 1'b1, 1'b0);
        prev = 8'h3C;
        // R3: request during trials is dropped
        convert(8'hC3, prev, ACQ - 2, 1'b0, 1'b1);
        expect_idle(3 * ACQ, "R3");
        chk(result == 8'hC3, "R3", "result after ignored request", int'(result), 'hC3);
        summary();
    end
endmodule